// File: doc/BRIEF.md
# Hit-Pattern Coincidence Trigger Processor

This block turns per-chip "any pixel hit" flags from a two-layer barrel of half-staves into ten trigger decisions per frame. Each half-stave supplies one flag per readout chip, ten chips per half-stave. A fresh set of all flags arrives once per 100 ns frame, marked by a one-cycle valid strobe. The half-staves are grouped into an inner and an outer layer, and a fixed, parameterised map tags each half-stave as belonging to the upper or the lower half of the barrel.

Before any decision is taken, a per-chip suppression mask zeroes the flags of noisy chips. The surviving flags are reduced to four region ORs (upper/lower × inner/outer) and to hit counts per layer. These counts are summed in a registered two-level adder tree and compared against host-set thresholds. Each of the ten algorithms has its own enable bit. A result word appears a fixed three clock edges after the frame is taken. It is held for one frame and then cleared.

The input side has no back-pressure: there is no ready signal, and a frame is accepted on every cycle that `frame_vld` is high. The output side is a one-cycle `trig_vld` pulse that the consumer must take when it appears. A later frame overwrites the held word.

Top module: `hit_coinc_trigger`

## Requirements
- R1: A chip flag whose bit in `mask_inner`/`mask_outer` is 1 is treated as 0 by every algorithm. Chip c of half-stave h sits at bit h*10+c of its layer's vector.
- R2: Bit 0 of `trig_word` is the AND of "any upper outer chip hit" and "any lower outer chip hit". The upper/lower tags come from OUT_UPPER, where bit h = 1 means upper.
- R3: Bit 1 is the AND of the outer-layer OR and the inner-layer OR.
- R4: Bit 3 is the AND of all four regions (upper outer, lower outer, upper inner, lower inner). Bit 4 is upper outer AND lower outer AND the inner-layer OR.
- R5: Bit 2 (double layer) fires when the inner hit count ≥ `thr_inner` and the outer hit count ≥ `thr_outer`. With both thresholds at 2, this means at least two hits in each layer.
- R6: Bit 6 is inner count ≥ `thr_inner`, bit 7 is outer count ≥ `thr_outer`, and bit 8 is inner+outer count ≥ `thr_total`. Equality fires.
- R7: Bit 5 is the OR of all unmasked flags. Bit 9 is upper inner AND lower inner.
- R8: An algorithm whose bit in `algo_en` is 0 gives 0 in `trig_word`.
- R9: A frame taken at clock edge E produces `trig_vld` = 1 and the new `trig_word` after edge E+2. `trig_vld` is high for that single cycle only.
- R10: `trig_word` holds its value for exactly HOLD_CYC cycles and then reads 0, unless a newer frame replaces it.
- R11: While `frame_vld` is 0, the flag inputs have no effect: `trig_word` and `trig_vld` do not change because of them.
- R12: After reset, `trig_word` is 0 and `trig_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe: flags are valid |
| hits_inner | input | N_INNER*10 | Inner-layer chip flags |
| hits_outer | input | N_OUTER*10 | Outer-layer chip flags |
| mask_inner | input | N_INNER*10 | Inner chip suppression, 1 = suppress |
| mask_outer | input | N_OUTER*10 | Outer chip suppression, 1 = suppress |
| thr_inner | input | CW | Inner multiplicity threshold |
| thr_outer | input | CW | Outer multiplicity threshold |
| thr_total | input | CW | Combined multiplicity threshold |
| algo_en | input | 10 | Per-algorithm enable |
| trig_vld | output | 1 | Pulse: new result word |
| trig_word | output | 10 | Registered algorithm results |

## Verification
Every decision is due after the third rising edge, counting the edge that samples `frame_vld`. The bench drives stimulus on falling edges and waits exactly three falling edges before it samples, so each check lands one half cycle after the result register updates. The hold window is then checked cycle by cycle: it must stay non-zero for HOLD_CYC samples and read zero on the next one. In every scenario the bench also confirms that `trig_vld` is high only in the first of those samples.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int CHIPS_PER_HS = 10;
  localparam int NUM_ALGOS    = 10;
  localparam int HS_CNT_W     = 4;

  // Algorithm bit positions within the result word
  localparam int A_OUT_UD    = 0;
  localparam int A_LAYERS    = 1;
  localparam int A_DLAYER    = 2;
  localparam int A_FOUR      = 3;
  localparam int A_OUT_UD_IN = 4;
  localparam int A_GLOBAL    = 5;
  localparam int A_MULT_IN   = 6;
  localparam int A_MULT_OUT  = 7;
  localparam int A_MULT_TOT  = 8;
  localparam int A_IN_UD     = 9;

  typedef struct packed {
    logic up_in;
    logic lo_in;
    logic up_out;
    logic lo_out;
  } region_t;

  function automatic logic [HS_CNT_W-1:0] pop_hs(input logic [CHIPS_PER_HS-1:0] v);
    logic [HS_CNT_W-1:0] s;
    s = '0;
    for (int i = 0; i < CHIPS_PER_HS; i++) s = s + HS_CNT_W'(v[i]);
    return s;
  endfunction
endpackage

// File: rtl/trg_mask_stage.sv
module trg_mask_stage #(
  parameter int W_IN  = 20,
  parameter int W_OUT = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_vld,
  input  logic [W_IN-1:0]  hits_in,
  input  logic [W_OUT-1:0] hits_out,
  input  logic [W_IN-1:0]  mask_in,
  input  logic [W_OUT-1:0] mask_out,
  output logic             s1_vld,
  output logic [W_IN-1:0]  s1_in,
  output logic [W_OUT-1:0] s1_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_in  <= '0;
      s1_out <= '0;
    end else begin
      s1_vld <= frame_vld;
      if (frame_vld) begin
        s1_in  <= hits_in & ~mask_in;
        s1_out <= hits_out & ~mask_out;
      end
    end
  end

  // R1: suppressed chips never reach the algorithms
  p_mask_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> ((s1_in & $past(mask_in)) == '0));
  p_mask_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> ((s1_out & $past(mask_out)) == '0));
endmodule

// File: rtl/trg_hs_reduce.sv
module trg_hs_reduce
  import trg_pkg::*;
#(
  parameter int              N_HS     = 2,
  parameter logic [N_HS-1:0] UPPER    = '0,
  localparam int             W        = N_HS * CHIPS_PER_HS
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           en,
  input  logic [W-1:0]                   bits,
  output logic                           up_or,
  output logic                           lo_or,
  output logic [N_HS-1:0][HS_CNT_W-1:0]  hs_cnt
);
  logic [N_HS-1:0] hs_any;

  for (genvar h = 0; h < N_HS; h++) begin : g_hs
    logic [CHIPS_PER_HS-1:0] seg;
    assign seg       = bits[h*CHIPS_PER_HS +: CHIPS_PER_HS];
    assign hs_any[h] = |seg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  hs_cnt[h] <= '0;
      else if (en) hs_cnt[h] <= pop_hs(seg);
    end

    // R6: a half-stave count never exceeds its chip count
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hs_cnt[h] <= HS_CNT_W'(CHIPS_PER_HS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_or <= 1'b0;
      lo_or <= 1'b0;
    end else if (en) begin
      up_or <= |(hs_any & UPPER);
      lo_or <= |(hs_any & ~UPPER);
    end
  end
endmodule

// File: rtl/trg_algo_eval.sv
module trg_algo_eval
  import trg_pkg::*;
#(
  parameter int N_IN     = 2,
  parameter int N_OUT    = 4,
  parameter int CW       = 6,
  parameter int HOLD_CYC = 5,
  localparam int HW      = $clog2(HOLD_CYC + 1)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            s2_vld,
  input  region_t                         reg_or,
  input  logic [N_IN-1:0][HS_CNT_W-1:0]   cnt_in_hs,
  input  logic [N_OUT-1:0][HS_CNT_W-1:0]  cnt_out_hs,
  input  logic [CW-1:0]                   thr_in,
  input  logic [CW-1:0]                   thr_out,
  input  logic [CW-1:0]                   thr_tot,
  input  logic [NUM_ALGOS-1:0]            algo_en,
  output logic                            trig_vld,
  output logic [NUM_ALGOS-1:0]            trig_word
);
  logic [CW-1:0]        sum_in, sum_out, sum_tot;
  logic [NUM_ALGOS-1:0] res;
  logic [HW-1:0]        hold;
  logic                 or_in, or_out, ud_out, ud_in;

  always_comb begin
    sum_in = '0;
    for (int h = 0; h < N_IN; h++) sum_in = sum_in + CW'(cnt_in_hs[h]);
    sum_out = '0;
    for (int h = 0; h < N_OUT; h++) sum_out = sum_out + CW'(cnt_out_hs[h]);
    sum_tot = sum_in + sum_out;
  end

  assign or_in  = reg_or.up_in | reg_or.lo_in;
  assign or_out = reg_or.up_out | reg_or.lo_out;
  assign ud_out = reg_or.up_out & reg_or.lo_out;
  assign ud_in  = reg_or.up_in & reg_or.lo_in;

  always_comb begin
    res              = '0;
    res[A_OUT_UD]    = ud_out;
    res[A_LAYERS]    = or_out & or_in;
    res[A_DLAYER]    = (sum_in >= thr_in) & (sum_out >= thr_out);
    res[A_FOUR]      = ud_out & ud_in;
    res[A_OUT_UD_IN] = ud_out & or_in;
    res[A_GLOBAL]    = or_out | or_in;
    res[A_MULT_IN]   = sum_in >= thr_in;
    res[A_MULT_OUT]  = sum_out >= thr_out;
    res[A_MULT_TOT]  = sum_tot >= thr_tot;
    res[A_IN_UD]     = ud_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_vld  <= 1'b0;
      trig_word <= '0;
      hold      <= '0;
    end else begin
      trig_vld <= s2_vld;
      if (s2_vld) begin
        trig_word <= res & algo_en;
        hold      <= HW'(HOLD_CYC - 1);
      end else if (hold != '0) begin
        hold <= hold - 1'b1;
      end else begin
        trig_word <= '0;
      end
    end
  end

  // R9: one valid pulse per frame, exactly one stage later
  p_vld_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld |=> trig_vld);
  p_vld_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_vld |=> !trig_vld);
  // R8: disabled algorithms report 0
  p_disabled_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_vld |-> ((trig_word & ~$past(algo_en)) == '0));
  // R10: the word changes only to a new result or to 0
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_word != '0 && !trig_vld) |-> (trig_word == $past(trig_word)));
  // R7: an upper+lower outer coincidence implies a global hit
  p_global_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_vld && trig_word[A_OUT_UD]) |-> (trig_word[A_GLOBAL] || !$past(algo_en[A_GLOBAL])));
endmodule

// File: rtl/hit_coinc_trigger.sv
module hit_coinc_trigger
  import trg_pkg::*;
#(
  parameter int               N_INNER   = 2,
  parameter int               N_OUTER   = 4,
  parameter logic [N_INNER-1:0] IN_UPPER  = 2'b01,
  parameter logic [N_OUTER-1:0] OUT_UPPER = 4'b0011,
  parameter int               HOLD_CYC  = 5,
  localparam int              WI        = N_INNER * CHIPS_PER_HS,
  localparam int              WO        = N_OUTER * CHIPS_PER_HS,
  localparam int              CW        = $clog2(WI + WO + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_vld,
  input  logic [WI-1:0]        hits_inner,
  input  logic [WO-1:0]        hits_outer,
  input  logic [WI-1:0]        mask_inner,
  input  logic [WO-1:0]        mask_outer,
  input  logic [CW-1:0]        thr_inner,
  input  logic [CW-1:0]        thr_outer,
  input  logic [CW-1:0]        thr_total,
  input  logic [NUM_ALGOS-1:0] algo_en,
  output logic                 trig_vld,
  output logic [NUM_ALGOS-1:0] trig_word
);
  logic          s1_vld, s2_vld;
  logic [WI-1:0] s1_in;
  logic [WO-1:0] s1_out;
  region_t       reg_or;
  logic [N_INNER-1:0][HS_CNT_W-1:0] cnt_in_hs;
  logic [N_OUTER-1:0][HS_CNT_W-1:0] cnt_out_hs;

  trg_mask_stage #(.W_IN(WI), .W_OUT(WO)) u_mask (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld),
    .hits_in(hits_inner), .hits_out(hits_outer),
    .mask_in(mask_inner), .mask_out(mask_outer),
    .s1_vld(s1_vld), .s1_in(s1_in), .s1_out(s1_out)
  );

  trg_hs_reduce #(.N_HS(N_INNER), .UPPER(IN_UPPER)) u_red_in (
    .clk(clk), .rst_n(rst_n), .en(s1_vld), .bits(s1_in),
    .up_or(reg_or.up_in), .lo_or(reg_or.lo_in), .hs_cnt(cnt_in_hs)
  );

  trg_hs_reduce #(.N_HS(N_OUTER), .UPPER(OUT_UPPER)) u_red_out (
    .clk(clk), .rst_n(rst_n), .en(s1_vld), .bits(s1_out),
    .up_or(reg_or.up_out), .lo_or(reg_or.lo_out), .hs_cnt(cnt_out_hs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_vld <= 1'b0;
    else        s2_vld <= s1_vld;
  end

  trg_algo_eval #(.N_IN(N_INNER), .N_OUT(N_OUTER), .CW(CW), .HOLD_CYC(HOLD_CYC)) u_eval (
    .clk(clk), .rst_n(rst_n), .s2_vld(s2_vld), .reg_or(reg_or),
    .cnt_in_hs(cnt_in_hs), .cnt_out_hs(cnt_out_hs),
    .thr_in(thr_inner), .thr_out(thr_outer), .thr_tot(thr_total),
    .algo_en(algo_en), .trig_vld(trig_vld), .trig_word(trig_word)
  );

  // R9: a result appears exactly after the third sampling edge
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> ##1 trig_vld);
endmodule

// File: tb/tb_hit_coinc_trigger.sv
module tb_hit_coinc_trigger;
  localparam int HOLD = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_vld = 1'b0;
  logic [19:0] hits_inner = '0, mask_inner = '0;
  logic [39:0] hits_outer = '0, mask_outer = '0;
  logic [5:0]  thr_inner = 6'd2, thr_outer = 6'd2, thr_total = 6'd3;
  logic [9:0]  algo_en = 10'h3FF;
  logic        trig_vld;
  logic [9:0]  trig_word;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  hit_coinc_trigger #(.HOLD_CYC(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld),
    .hits_inner(hits_inner), .hits_outer(hits_outer),
    .mask_inner(mask_inner), .mask_outer(mask_outer),
    .thr_inner(thr_inner), .thr_outer(thr_outer), .thr_total(thr_total),
    .algo_en(algo_en), .trig_vld(trig_vld), .trig_word(trig_word)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one frame and sample the result three edges later
  task automatic frame(input logic [19:0] fi, input logic [39:0] fo,
                       input logic [9:0] exp, input string req);
    @(negedge clk);
    frame_vld = 1'b1; hits_inner = fi; hits_outer = fo;
    @(negedge clk);
    frame_vld = 1'b0; hits_inner = '0; hits_outer = '0;
    repeat (2) @(negedge clk);
    chk(32'(trig_word), 32'(exp), req);
    chk(32'(trig_vld), 32'd1, "R9 valid pulse");
  endtask

  task automatic settle();
    repeat (HOLD + 3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(32'(trig_word), 0, "R12 word");
    chk(32'(trig_vld), 0, "R12 valid");
  endtask

  task automatic t_regions();
    // upper inner chip, upper outer chip, lower outer chip
    frame(20'h00001, 40'h00001_00001, 10'h1B3, "R2 R3 R4 R6 R7 one-inner");
    settle();
    // all four regions, two hits per layer
    frame(20'h00401, 40'h02000_00020, 10'h3FF, "R2 R3 R4 R5 R6 R7 all-regions");
    settle();
  endtask

  task automatic t_mask();
    mask_inner = 20'h00400;
    frame(20'h00401, 40'h02000_00020, 10'h1B3, "R1 masked lower inner");
    mask_inner = '0;
    settle();
  endtask

  task automatic t_thresholds();
    frame(20'h00007, 40'h00000_00003, 10'h1E6, "R5 R6 three inner two outer");
    settle();
    thr_inner = 6'd4;
    frame(20'h00007, 40'h00000_00003, 10'h1A2, "R5 R6 below threshold");
    settle();
    thr_inner = 6'd3;
    frame(20'h00007, 40'h00000_00003, 10'h1E6, "R6 equality fires");
    settle();
    thr_inner = 6'd2;
    frame(20'h00000, 40'h00000_00000, 10'h000, "R7 empty frame");
    settle();
  endtask

  task automatic t_disable();
    algo_en = 10'h2AA;
    frame(20'h00401, 40'h02000_00020, 10'h2AA, "R8 half disabled");
    algo_en = 10'h3FF;
    settle();
  endtask

  task automatic t_hold();
    frame(20'h00401, 40'h02000_00020, 10'h3FF, "R10 load");
    for (int k = 1; k < HOLD; k++) begin
      @(negedge clk);
      chk(32'(trig_word), 32'h3FF, "R10 held");
      chk(32'(trig_vld), 0, "R9 single pulse");
    end
    @(negedge clk);
    chk(32'(trig_word), 0, "R10 cleared");
    settle();
  endtask

  task automatic t_ignore();
    @(negedge clk);
    hits_inner = '1; hits_outer = '1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(32'(trig_word), 0, "R11 word unchanged");
      chk(32'(trig_vld), 0, "R11 no pulse");
    end
    hits_inner = '0; hits_outer = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regions();
    t_mask();
    t_thresholds();
    t_disable();
    t_hold();
    t_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule